// File: doc/BRIEF.md
# Dual-Port Channel Buffer Serial Bridge

This block connects a 2048 kbit/s time-division serial link to a small controller port. Two transmit buffers hold one byte per channel slot, and each buffer is shifted out on its own serial output. A single receive buffer collects one byte per slot from the serial input. The controller writes transmit bytes, choosing the buffer with a bank bit, and reads receive bytes through a plain address/data port.

The serial side runs from a 4.096 MHz clock at two clocks per bit. An active-low frame pulse marks the last clock of a frame. A frame carries 32 slots of 8 bits, sent most significant bit first. A select input reduces the live slots to the first 24. The serial side reaches the RAM twice per slot: it prefetches the next slot's transmit bytes and it stores the received byte. A combinational busy flag tells the controller that it has hit the location used in that cycle, and the stalled access is dropped so the controller can retry.

Top module: `chan_ram_bridge`

## Requirements
- R1: Frame counter: a low `fp_n` makes the next clock the first clock of slot 0, bit 0. A frame is 512 clocks with 16 clocks per slot and 2 clocks per bit, and bits go most significant first.
- R2: Throughout slot s, `ser_out0` carries the byte that transmit buffer 0 held at address s when that byte was prefetched. A controller write with `cpu_bank`=0 updates buffer 0 only.
- R3: Throughout slot s, `ser_out1` carries buffer 1 address s in the same way. A controller write with `cpu_bank`=1 updates buffer 1 only.
- R4: `cpu_rdata` always shows receive buffer address `cpu_addr`, whatever the value of `cpu_bank`.
- R5: `ser_in` is sampled on the second clock of each bit. On the last clock of a live slot s (clock index 15 within the slot), the assembled byte is written to receive address s.
- R6: When `ch32`=0, slots 24 to 31 drive both outputs high and leave the receive buffer unchanged.
- R7: The transmit prefetch happens on clock index 8 of slot s and reads address (s+1) mod 32, but only when that slot is live. A controller write to that address in that cycle raises `busy` and is discarded.
- R8: A controller read of address s on clock index 15 of a live slot s raises `busy`.
- R9: `busy` is low in every other cycle, including every cycle in which `cpu_en` is low.
- R10: While in reset, both serial outputs are high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock, two per serial bit |
| rst_n | input | 1 | Active-low reset |
| fp_n | input | 1 | Active-low frame pulse, on the last clock of a frame |
| ch32 | input | 1 | 1 = 32 live slots, 0 = 24 live slots |
| cpu_en | input | 1 | Controller access strobe |
| cpu_we | input | 1 | 1 = write a transmit buffer, 0 = read the receive buffer |
| cpu_bank | input | 1 | Transmit buffer select for writes |
| cpu_addr | input | 5 | Slot address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Receive buffer data at `cpu_addr` |
| busy | output | 1 | Access collides with the serial side this cycle |
| ser_in | input | 1 | Serial receive stream |
| ser_out0 | output | 1 | Serial stream from transmit buffer 0 |
| ser_out1 | output | 1 | Serial stream from transmit buffer 1 |

## Verification
If the bit counter is off, every later slot shifts, so a wrong phase shows up as a byte mismatch on both outputs within one slot, or 16 clocks. A stale prefetch register or a collided write that lands anyway corrupts exactly one slot byte. That byte appears one slot after the fetch, or in the next frame. A receive shift or store fault shows up on the first controller read of the affected address. A misplaced busy window shows up in the same cycle as the access.

// File: rtl/chan_ram_bridge.sv
module chan_ram_bridge #(
  parameter int AW       = 5,
  parameter int SHORT_CH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  input  logic          ch32,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic          cpu_bank,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          busy,
  input  logic          ser_in,
  output logic          ser_out0,
  output logic          ser_out1
);
  localparam int SLOTS = 1 << AW;
  localparam logic [AW-1:0] LAST_SHORT = AW'(SHORT_CH - 1);

  logic [AW+3:0] cnt;
  logic [AW-1:0] slot, nslot;
  logic [3:0]    ph;
  logic [7:0]    tx0 [SLOTS];
  logic [7:0]    tx1 [SLOTS];
  logic [7:0]    rx  [SLOTS];
  logic [7:0]    pre0, pre1, cur0, cur1, rsh;
  logic          fetch_ok, store_ok, cpu_wr;

  assign slot  = cnt[AW+3:4];
  assign ph    = cnt[3:0];
  assign nslot = slot + 1'b1;

  assign fetch_ok = (ph == 4'd8)  && (ch32 || nslot <= LAST_SHORT);
  assign store_ok = (ph == 4'd15) && (ch32 || slot  <= LAST_SHORT);

  assign busy = cpu_en && (cpu_we ? (fetch_ok && cpu_addr == nslot)
                                  : (store_ok && cpu_addr == slot));
  assign cpu_wr    = cpu_en && cpu_we && !busy;
  assign cpu_rdata = rx[cpu_addr];

  assign ser_out0 = cur0[~cnt[3:1]];
  assign ser_out1 = cur1[~cnt[3:1]];

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!fp_n) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cpu_wr && !cpu_bank) tx0[cpu_addr] <= cpu_wdata;
    if (cpu_wr &&  cpu_bank) tx1[cpu_addr] <= cpu_wdata;
    if (store_ok)            rx[slot]      <= {rsh[6:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsh  <= '0;
      pre0 <= 8'hFF;
      pre1 <= 8'hFF;
      cur0 <= 8'hFF;
      cur1 <= 8'hFF;
    end else begin
      if (ph[0]) rsh <= {rsh[6:0], ser_in};
      if (ph == 4'd8) begin
        pre0 <= fetch_ok ? tx0[nslot] : 8'hFF;
        pre1 <= fetch_ok ? tx1[nslot] : 8'hFF;
      end
      if (ph == 4'd15) begin
        cur0 <= pre0;
        cur1 <= pre1;
      end
    end
  end

  assert_frame_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> cnt == '0);

  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_n && &cnt) |=> cnt == '0);

  assert_tx0_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && !cpu_bank) |=> tx0[$past(cpu_addr)] == $past(tx0[cpu_addr]));

  assert_tx1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && cpu_bank) |=> tx1[$past(cpu_addr)] == $past(tx1[cpu_addr]));

  assert_rx_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |=> rx[$past(slot)] == $past({rsh[6:0], ser_in}));

  assert_blank_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 4'd8 && !fetch_ok) |=> (pre0 == 8'hFF && pre1 == 8'hFF));

  assert_busy_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> !busy);
endmodule

// File: tb/tb_chan_ram_bridge.sv
module tb_chan_ram_bridge;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, fp_n, ch32, cpu_en, cpu_we, cpu_bank, ser_in;
  logic [4:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       busy, ser_out0, ser_out1;

  chan_ram_bridge dut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ch32(ch32),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_bank(cpu_bank),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .busy(busy), .ser_in(ser_in), .ser_out0(ser_out0), .ser_out1(ser_out1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit         op_v  [512];
  bit         op_we [512];
  bit         op_bk [512];
  logic [4:0] op_a  [512];
  logic [7:0] op_d  [512];

  logic [7:0] m0 [32];
  logic [7:0] m1 [32];
  logic [7:0] mrx [32];
  logic [7:0] pat [32];
  logic [7:0] ecur0, ecur1, enx0, enx1;
  bit mode32 = 1;

  function automatic bit live(int s, bit m);
    return m || s < 24;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic add_op(int k, bit we, bit bk, int a, logic [7:0] d);
    op_v[k] = 1; op_we[k] = we; op_bk[k] = bk; op_a[k] = 5'(a); op_d[k] = d;
  endtask

  task automatic set_pat(int seed);
    for (int i = 0; i < 32; i++) pat[i] = 8'((i * 37 + seed * 91 + 5) ^ (seed << 3));
  endtask

  // One full frame starting at a negedge with the design counter at 0 (R1).
  task automatic run_frame();
    bit quiet_ok = 1;
    logic [7:0] a0 = 0, a1 = 0;
    for (int k = 0; k < 512; k++) begin
      int s = k / 16;
      int ph = k % 16;
      int ns = (s + 1) % 32;
      bit ebusy;
      string tag;
      fp_n = (k == 511) ? 1'b0 : 1'b1;
      ch32 = mode32;
      ser_in = pat[s][7 - ph / 2];
      cpu_en = op_v[k]; cpu_we = op_we[k]; cpu_bank = op_bk[k];
      cpu_addr = op_a[k]; cpu_wdata = op_d[k];
      #1;
      if (ph % 2 == 1) begin
        a0 = {a0[6:0], ser_out0};
        a1 = {a1[6:0], ser_out1};
      end
      if (ph == 8) begin
        enx0 = live(ns, mode32) ? m0[ns] : 8'hFF;
        enx1 = live(ns, mode32) ? m1[ns] : 8'hFF;
      end
      if (op_v[k]) begin
        ebusy = op_we[k] ? (ph == 8 && live(ns, mode32) && int'(op_a[k]) == ns)
                         : (ph == 15 && live(s, mode32) && int'(op_a[k]) == s);
        tag = !ebusy ? "R9 busy" : (op_we[k] ? "R7 busy" : "R8 busy");
        check(busy == ebusy, tag, 32'(busy), 32'(ebusy));
        if (!op_we[k] && !ebusy)
          check(cpu_rdata == mrx[op_a[k]], op_bk[k] ? "R4 read" : "R5 read",
                32'(cpu_rdata), 32'(mrx[op_a[k]]));
        if (op_we[k] && !ebusy) begin
          if (op_bk[k]) m1[op_a[k]] = op_d[k];
          else          m0[op_a[k]] = op_d[k];
        end
      end else if (busy) quiet_ok = 0;
      if (ph == 15) begin
        if (!mode32 && s >= 24) begin
          check(a0 == ecur0, "R6 out0 blank", 32'(a0), 32'(ecur0));
          check(a1 == ecur1, "R6 out1 blank", 32'(a1), 32'(ecur1));
        end else begin
          check(a0 == ecur0, "R1/R2 out0", 32'(a0), 32'(ecur0));
          check(a1 == ecur1, "R1/R3 out1", 32'(a1), 32'(ecur1));
        end
        ecur0 = enx0;
        ecur1 = enx1;
        if (live(s, mode32)) mrx[s] = pat[s];
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(quiet_ok, "R9 idle busy", 32'(!quiet_ok), 0);
    for (int k = 0; k < 512; k++) op_v[k] = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; fp_n = 0; ch32 = 1; cpu_en = 0; cpu_we = 0; cpu_bank = 0;
    cpu_addr = 0; cpu_wdata = 0; ser_in = 1;
    repeat (3) @(negedge clk);
    #1;
    check(ser_out0 == 1'b1, "R10 out0", 32'(ser_out0), 1);
    check(ser_out1 == 1'b1, "R10 out1", 32'(ser_out1), 1);
    check(busy == 1'b0, "R10 busy", 32'(busy), 0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    fp_n = 1;
  endtask

  // R2 R3: fill both banks, then rewrite bank 1 only.
  task automatic t_tx_banks();
    set_pat(1);
    for (int i = 0; i < 32; i++) begin
      add_op(16 * ((i + 31) % 32) + 2, 1, 0, i, 8'(8'hA0 + i));
      add_op(16 * ((i + 31) % 32) + 4, 1, 1, i, 8'(8'h3C ^ (i * 7)));
    end
    run_frame();
    set_pat(2);
    for (int i = 0; i < 32; i += 3) add_op(16 * i + 6, 1, 1, i, 8'(8'h55 + i));
    run_frame();
    run_frame();
  endtask

  // R4 R5: capture a pattern, then read it back with both bank values.
  task automatic t_rx_read();
    set_pat(3);
    run_frame();
    set_pat(4);
    for (int i = 0; i < 32; i++) add_op(16 * i + 3, 0, i[0], i, 0);
    run_frame();
  endtask

  // R6: 24-slot frame, then read back every address in a 32-slot frame.
  task automatic t_short_mode();
    mode32 = 0;
    set_pat(5);
    add_op(16 * 23 + 8, 1, 0, 24, 8'h11);
    add_op(16 * 25 + 15, 0, 0, 25, 0);
    run_frame();
    run_frame();
    mode32 = 1;
    set_pat(6);
    for (int i = 0; i < 32; i++) add_op(16 * i + 3, 0, 0, i, 0);
    run_frame();
  endtask

  // R7 R8: colliding accesses raise busy and the write is dropped.
  task automatic t_collide();
    set_pat(7);
    add_op(16 * 5 + 8, 1, 0, 6, 8'hEE);
    add_op(16 * 7 + 8, 1, 1, 8, 8'hDD);
    add_op(16 * 12 + 8, 1, 0, 3, 8'h77);
    add_op(16 * 31 + 8, 1, 1, 0, 8'h99);
    add_op(16 * 9 + 15, 0, 0, 9, 0);
    add_op(16 * 10 + 15, 0, 1, 11, 0);
    add_op(16 * 14 + 14, 0, 0, 14, 0);
    run_frame();
    run_frame();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      m0[i] = 8'hFF; m1[i] = 8'hFF; mrx[i] = 8'h00; pat[i] = 8'h00;
    end
    for (int k = 0; k < 512; k++) op_v[k] = 0;
    ecur0 = 8'hFF; ecur1 = 8'hFF; enx0 = 8'hFF; enx1 = 8'hFF;
    t_reset();
    t_tx_banks();
    t_rx_read();
    t_short_mode();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule